// File: doc/BRIEF.md
# PRBS7 Training-Locked Lane Scrambler

This block is a matched transmitter and receiver for a raw serial lane that has no line coding. It moves one W-bit word per clock. After reset, or on request, the transmitter sends a bare PRBS7 stream. The receiver copies its own generator state out of that stream and confirms the state against a run of following words. It then reports lock. From then on each payload word is XORed with the running sequence on transmit. The receiver XORs it again with its own aligned copy. The scrambled lane keeps enough bit transitions for AC coupling and for a lock-to-data clock recovery loop, and no overhead bits are added.

The far-end ready input tells the transmitter when the opposite receiver has locked. In a loopback, or when two ends face each other, it is tied to that receiver's lock output. Within a word, bit 0 is the earliest bit in time. The serializer, clock recovery and word or lane alignment sit outside the block.

Back-pressure rules: the payload input is a valid/ready stream. The ready signal is high only in data mode. The transmitter never stalls the lane. A data-mode cycle with ready high and valid low sends a zero payload. The receive output has no ready input, because a raw lane cannot pause: every word marked valid must be taken in its cycle.

Top module: `prbs7_link`

## Requirements
- R1: While training, the transmitter holds payload ready low and puts out the bare sequence of x^7 + x^6 + 1: every lane bit equals the XOR of the bits 7 and 6 positions earlier, with bit 0 of a word the earliest.
- R2: Reset clears ready, valid, lock and the error count. The transmitter enters data mode (ready high) after any clock edge where far-end ready is high and start-training is low. It falls back to training after an edge where either condition fails.
- R3: The lane word in data mode is the payload XOR the next sequence word. A ready slot without valid carries zero payload. The first data word continues the sequence with no gap after the last training word.
- R4: The receiver seeds its generator from the 7 latest bits of a received word (bits W-7 to W-1). A seed candidate of all zeros is ignored, and the receiver stays in seeding, so an idle all-zero lane never produces lock.
- R5: Lock is declared only after LOCK_N consecutive words match the prediction following a seed. A clean training stream gives lock within LOCK_N+4 clocks.
- R6: A mismatch during verification adds exactly one to the error count (saturating). It restarts the match count and reseeds from the mismatching word.
- R7: While locked, the receiver marks every word valid and recovers the payload bit-exactly, one clock after the word reaches its lane input. The receive output is never valid while unlocked.
- R8: A single bit flipped on the lane in data mode corrupts exactly that bit of that one output word, and later words are unaffected.
- R9: Asserting loss-of-lock or start-training drops lock on the next clock and returns the receiver to seeding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| start_train | input | 1 | Forces both halves back to training or seeding |
| far_ready | input | 1 | Far-end receiver locked; allows transmit data mode |
| s_valid | input | 1 | Payload word offered |
| s_ready | output | 1 | Payload accepted this cycle (transmitter in data mode) |
| s_data | input | W | Payload word |
| lane_tx | output | W | Registered word sent to the lane |
| lane_rx | input | W | Word received from the lane |
| loss_of_lock | input | 1 | External lock-loss indication for the receiver |
| m_valid | output | 1 | Recovered word valid |
| m_data | output | W | Recovered payload word |
| rx_locked | output | 1 | Receiver locked and descrambling |
| err_count | output | ERR_W | Saturating count of verification mismatches |

## Verification
The assertions check these rules on every cycle: ready only rises after far-end ready, start-training or loss-of-lock drops lock on the next clock, no output is valid while unlocked, the error count never steps by more than one, and lock never comes sooner than one seeding cycle plus LOCK_N matching words. Some behaviour can only be shown by the bench's scenarios. These are that the lane stream truly follows the polynomial across the training-to-data boundary, bit-exact payload recovery, the single-bit error footprint swept over every bit position, the refusal of an all-zero seed, and relock timing after repeated restarts at arbitrary sequence offsets.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;
  localparam int SEQ_LEN = 7;
  localparam int TAP_HI  = 6;
  localparam int TAP_LO  = 5;

  typedef enum logic [1:0] {
    RX_SEED   = 2'd0,
    RX_VERIFY = 2'd1,
    RX_DATA   = 2'd2
  } rx_state_t;

  typedef enum logic {
    TX_TRAIN = 1'b0,
    TX_DATA  = 1'b1
  } tx_state_t;
endpackage

// File: rtl/prbs7_step.sv
// Advances a PRBS7 state by W bits in one clock and yields the W bits emitted.
module prbs7_step
  import prbs7_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [SEQ_LEN-1:0] cur,
  output logic [W-1:0]       word,
  output logic [SEQ_LEN-1:0] nxt
);
  logic [SEQ_LEN-1:0] s;
  logic               b;

  always_comb begin
    s = cur;
    b = 1'b0;
    word = '0;
    for (int i = 0; i < W; i++) begin
      b       = s[TAP_HI] ^ s[TAP_LO];
      word[i] = b;
      s       = {s[SEQ_LEN-2:0], b};
    end
    nxt = s;
  end
endmodule

// File: rtl/prbs7_tx.sv
module prbs7_tx
  import prbs7_pkg::*;
#(
  parameter int                 W       = 16,
  parameter logic [SEQ_LEN-1:0] TX_SEED = 7'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_train,
  input  logic         far_ready,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic [W-1:0] lane_tx
);
  tx_state_t          st;
  logic [SEQ_LEN-1:0] lfsr;
  logic [SEQ_LEN-1:0] lfsr_nxt;
  logic [W-1:0]       seq_word;
  logic [W-1:0]       payload;

  prbs7_step #(.W(W)) u_gen (
    .cur  (lfsr),
    .word (seq_word),
    .nxt  (lfsr_nxt)
  );

  assign s_ready = (st == TX_DATA);
  assign payload = (s_ready && s_valid) ? s_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= TX_TRAIN;
      lfsr    <= TX_SEED;
      lane_tx <= '0;
    end else begin
      lfsr    <= lfsr_nxt;
      lane_tx <= seq_word ^ payload;
      if (start_train || !far_ready) st <= TX_TRAIN;
      else                           st <= TX_DATA;
    end
  end
endmodule

// File: rtl/prbs7_rx.sv
module prbs7_rx
  import prbs7_pkg::*;
#(
  parameter int W      = 16,
  parameter int LOCK_N = 16,
  parameter int ERR_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_train,
  input  logic             loss_of_lock,
  input  logic [W-1:0]     lane_rx,
  output logic             m_valid,
  output logic [W-1:0]     m_data,
  output logic             rx_locked,
  output logic [ERR_W-1:0] err_count
);
  localparam int CW = (LOCK_N < 2) ? 1 : $clog2(LOCK_N + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_N - 1);

  rx_state_t          st;
  logic [SEQ_LEN-1:0] lfsr;
  logic [SEQ_LEN-1:0] lfsr_nxt;
  logic [W-1:0]       pred;
  logic [SEQ_LEN-1:0] seed_c;
  logic [CW-1:0]      cnt;
  logic               drop;
  logic               match;

  prbs7_step #(.W(W)) u_gen (
    .cur  (lfsr),
    .word (pred),
    .nxt  (lfsr_nxt)
  );

  // Latest received bit lands in seed_c[0], the oldest of the seven in seed_c[6].
  for (genvar k = 0; k < SEQ_LEN; k++) begin : g_seed
    assign seed_c[k] = lane_rx[W-1-k];
  end

  assign drop      = start_train || loss_of_lock;
  assign match     = (lane_rx == pred);
  assign rx_locked = (st == RX_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= RX_SEED;
      lfsr      <= '0;
      cnt       <= '0;
      m_valid   <= 1'b0;
      m_data    <= '0;
      err_count <= '0;
    end else begin
      m_valid <= 1'b0;
      if (drop) begin
        st  <= RX_SEED;
        cnt <= '0;
      end else begin
        unique case (st)
          RX_SEED: begin
            cnt <= '0;
            if (seed_c != '0) begin
              lfsr <= seed_c;
              st   <= RX_VERIFY;
            end
          end
          RX_VERIFY: begin
            if (match) begin
              lfsr <= lfsr_nxt;
              if (cnt == LAST) begin
                st  <= RX_DATA;
                cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else begin
              cnt  <= '0;
              lfsr <= seed_c;
              if (seed_c == '0) st <= RX_SEED;
              if (err_count != '1) err_count <= err_count + 1'b1;
            end
          end
          RX_DATA: begin
            m_valid <= 1'b1;
            m_data  <= lane_rx ^ pred;
            lfsr    <= lfsr_nxt;
          end
          default: st <= RX_SEED;
        endcase
      end
    end
  end
endmodule

// File: rtl/prbs7_link.sv
module prbs7_link
  import prbs7_pkg::*;
#(
  parameter int                 W       = 16,
  parameter int                 LOCK_N  = 16,
  parameter logic [SEQ_LEN-1:0] TX_SEED = 7'h5A,
  parameter int                 ERR_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_train,
  input  logic             far_ready,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [W-1:0]     s_data,
  output logic [W-1:0]     lane_tx,
  input  logic [W-1:0]     lane_rx,
  input  logic             loss_of_lock,
  output logic             m_valid,
  output logic [W-1:0]     m_data,
  output logic             rx_locked,
  output logic [ERR_W-1:0] err_count
);
  prbs7_tx #(.W(W), .TX_SEED(TX_SEED)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_train (start_train),
    .far_ready   (far_ready),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .s_data      (s_data),
    .lane_tx     (lane_tx)
  );

  prbs7_rx #(.W(W), .LOCK_N(LOCK_N), .ERR_W(ERR_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_train  (start_train),
    .loss_of_lock (loss_of_lock),
    .lane_rx      (lane_rx),
    .m_valid      (m_valid),
    .m_data       (m_data),
    .rx_locked    (rx_locked),
    .err_count    (err_count)
  );
endmodule

// File: rtl/prbs7_link_checker.sv
module prbs7_link_checker #(
  parameter int LOCK_N = 16,
  parameter int ERR_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_train,
  input logic             far_ready,
  input logic             loss_of_lock,
  input logic             s_ready,
  input logic             m_valid,
  input logic             rx_locked,
  input logic [ERR_W-1:0] err_count
);
  localparam int UW = $clog2(LOCK_N + 2);
  localparam logic [UW-1:0] MIN_LOW = UW'(LOCK_N + 1);

  logic [UW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                  low_run <= '0;
    else if (rx_locked)          low_run <= '0;
    else if (low_run != MIN_LOW) low_run <= low_run + 1'b1;
  end

  assert_ready_after_far_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ready) |-> $past(far_ready));

  assert_start_trains_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_train |=> !s_ready);

  assert_lock_min_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_locked) |-> (low_run >= MIN_LOW));

  assert_err_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |-> (err_count == $past(err_count) + 1'b1));

  assert_valid_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> rx_locked);

  assert_unlocked_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_locked |=> !m_valid);

  assert_drop_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_train || loss_of_lock) |=> !rx_locked);
endmodule

bind prbs7_link prbs7_link_checker #(.LOCK_N(LOCK_N), .ERR_W(ERR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_train  (start_train),
  .far_ready    (far_ready),
  .loss_of_lock (loss_of_lock),
  .s_ready      (s_ready),
  .m_valid      (m_valid),
  .rx_locked    (rx_locked),
  .err_count    (err_count)
);

// File: tb/prbs7_link_tb.sv
`timescale 1ns/1ps
module prbs7_link_tb;
  localparam int W      = 16;
  localparam int LOCK_N = 16;
  localparam int ERR_W  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_train = 1'b0;
  logic             s_valid = 1'b0;
  logic [W-1:0]     s_data = '0;
  logic             loss_of_lock = 1'b0;
  logic [W-1:0]     inj = '0;
  logic             ovr = 1'b0;
  logic             s_ready;
  logic [W-1:0]     lane_tx;
  logic [W-1:0]     lane_rx;
  logic             m_valid;
  logic [W-1:0]     m_data;
  logic             rx_locked;
  logic [ERR_W-1:0] err_count;

  int checks = 0;
  int errors = 0;
  logic [6:0] hist = '0;
  bit hist_ok = 1'b0;

  always #2.5 clk = ~clk;

  assign lane_rx = ovr ? '0 : (lane_tx ^ inj);

  prbs7_link #(.W(W), .LOCK_N(LOCK_N), .TX_SEED(7'h13), .ERR_W(ERR_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_train  (start_train),
    .far_ready    (rx_locked),
    .s_valid      (s_valid),
    .s_ready      (s_ready),
    .s_data       (s_data),
    .lane_tx      (lane_tx),
    .lane_rx      (lane_rx),
    .loss_of_lock (loss_of_lock),
    .m_valid      (m_valid),
    .m_data       (m_data),
    .rx_locked    (rx_locked),
    .err_count    (err_count)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Polynomial recurrence on the lane bit stream, bit 0 earliest.
  task automatic lane_seq(input logic [W-1:0] w, input string req);
    logic [W-1:0] exp;
    exp = '0;
    for (int i = 0; i < W; i++) begin
      exp[i] = hist[6] ^ hist[5];
      hist   = {hist[5:0], w[i]};
    end
    if (hist_ok) check(w == exp, req, w, exp);
    hist_ok = 1'b1;
  endtask

  task automatic wait_lock(output int n);
    n = 0;
    while (!rx_locked && n < 1000) begin
      tick();
      n++;
    end
  endtask

  task automatic run_data(input int words);
    logic [W-1:0] d1, d2, cur;
    bit a1, a2, slot;
    a1 = 0; a2 = 0; d1 = '0; d2 = '0;
    for (int j = 0; j < words; j++) begin
      s_valid = ($urandom % 5) != 0;
      s_data  = W'($urandom);
      slot    = s_ready;
      cur     = s_valid ? s_data : '0;
      tick();
      a2 = a1; d2 = d1;
      a1 = slot; d1 = cur;
      if (a2) begin
        check(m_valid == 1'b1, "R7 valid", m_valid, 1);
        check(m_data == d2, "R7 R3 data", m_data, d2);
      end
    end
    s_valid = 1'b0;
  endtask

  initial begin
    int n;
    bit prev_lock;
    bit ever_locked;
    logic [ERR_W-1:0] base;
    logic [W-1:0] x, y, bitm;

    repeat (4) tick();
    check(s_ready == 1'b0, "R2 reset ready", s_ready, 0);
    check(m_valid == 1'b0, "R2 reset valid", m_valid, 0);
    check(rx_locked == 1'b0, "R5 reset lock", rx_locked, 0);
    check(err_count == '0, "R6 reset errors", err_count, 0);

    // Bring-up from reset: training stream, lock timing, continuity into data mode.
    rst_n = 1'b1;
    n = 0; prev_lock = 0;
    while (!rx_locked && n < 200) begin
      tick();
      n++;
      lane_seq(lane_tx, "R1 training sequence");
      if (!prev_lock) check(s_ready == 1'b0, "R1 ready low in training", s_ready, 0);
      prev_lock = rx_locked;
    end
    check(n >= LOCK_N + 1 && n <= LOCK_N + 4, "R5 lock time", n, LOCK_N + 2);
    for (int j = 0; j < 5; j++) begin
      tick();
      lane_seq(lane_tx, "R3 sequence continuity");
    end
    check(s_ready == 1'b1, "R2 data mode", s_ready, 1);

    run_data(300);

    // R8: single-bit lane error swept over every bit position.
    for (int b = 0; b < W; b++) begin
      bitm = W'(1) << b;
      x = W'($urandom); y = W'($urandom);
      s_valid = 1'b1; s_data = x;
      tick();
      inj = bitm; s_data = y;
      tick();
      inj = '0;
      check(m_data == (x ^ bitm), "R8 flipped bit", m_data, x ^ bitm);
      check($countones(m_data ^ x) == 1, "R8 single bit", $countones(m_data ^ x), 1);
      s_data = W'($urandom);
      tick();
      check(m_data == y, "R8 no propagation", m_data, y);
    end
    s_valid = 1'b0;

    // R9 / R5: repeated restarts and lock losses at varying sequence offsets.
    for (int it = 0; it < 12; it++) begin
      if (it % 2 == 0) begin
        s_valid = 1'b0;
        start_train = 1'b1;
        tick();
        start_train = 1'b0;
        check(s_ready == 1'b0, "R2 start returns tx to training", s_ready, 0);
      end else begin
        s_valid = 1'b1; s_data = W'($urandom);
        loss_of_lock = 1'b1;
        tick();
        loss_of_lock = 1'b0;
        s_valid = 1'b0;
      end
      check(rx_locked == 1'b0, "R9 lock dropped", rx_locked, 0);
      wait_lock(n);
      check(n >= LOCK_N + 1 && n <= LOCK_N + 4, "R5 relock time", n, LOCK_N + 3);
      repeat (2 + (it % 3)) tick();
      run_data(20);
    end

    // R6: one corrupted training word, bit 0 (outside the seed bits).
    s_valid = 1'b0;
    start_train = 1'b1;
    tick();
    start_train = 1'b0;
    repeat (3) tick();
    base = err_count;
    inj = W'(1);
    tick();
    inj = '0;
    tick();
    check(err_count == base + 1'b1, "R6 mismatch counted once", err_count, base + 1'b1);
    check(rx_locked == 1'b0, "R6 match run restarted", rx_locked, 0);
    wait_lock(n);
    check(n >= LOCK_N - 2 && n <= LOCK_N + 4, "R6 relock after reseed", n, LOCK_N);
    repeat (2) tick();
    run_data(20);

    // R4: an all-zero lane must never seed or lock.
    base = err_count;
    s_valid = 1'b0;
    ovr = 1'b1;
    start_train = 1'b1;
    tick();
    start_train = 1'b0;
    ever_locked = 0;
    for (int j = 0; j < 3 * LOCK_N; j++) begin
      tick();
      if (rx_locked) ever_locked = 1;
    end
    check(ever_locked == 1'b0, "R4 zero lane no lock", ever_locked, 0);
    check(err_count == base, "R4 zero seed ignored", err_count, base);
    ovr = 1'b0;
    wait_lock(n);
    check(n >= LOCK_N + 1 && n <= LOCK_N + 4, "R4 lock after zeros", n, LOCK_N + 1);
    repeat (2) tick();
    run_data(40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule